// File: doc/BRIEF.md
# Transfer Bus Yield Controller

This block runs the bus phases of a descriptor-driven data mover and decides, at each phase boundary, whether to hand the external bus to a CPU that wants it. A transfer starts from an idle state. It then runs five kinds of phase in a fixed order: a vector fetch, one idle (NOP) phase, a descriptor fetch, one data phase per round, and a descriptor write-back. Each phase ends when the modelled bus raises its phase-done strobe.

A CPU request is latched as soon as it is seen. It is served only at a boundary that the current policy allows. While the bus is granted, the sequencer stalls. When the CPU drops its request, the sequencer continues with the phase that would have come next.

Three policy bits choose the allowed boundaries. They live in a 16-bit control word:
- The hold-all bit opens every boundary.
- Yield-select-A moves the release point from the NOP phase to the data rounds.
- Yield-select-B keeps the bus for the whole transfer and overrides yield-select-A.

When no transfer is running, a pending request is granted directly.

Top module: `bus_yield_ctrl`

## Requirements
- R1: The sequencer works through its phases in a fixed order after an accepted start: vector fetch, NOP, descriptor fetch, N data rounds, write-back, then idle.
  - `bus_phase` shows the current phase with these codes: 0 idle, 1 vector fetch, 2 NOP, 3 descriptor fetch, 4 data, 5 write-back, 6 granted to the CPU.
  - A phase advances only in a cycle where `bus_phase_done` is 1. While `bus_phase_done` is 0, the phase holds.
- R2: The policy bits sit in the control word at these positions: bit 15 is hold-all, bit 14 is yield-select-A and bit 12 is yield-select-B.
  - Each bit is written by `cfg_we` and reads back on `cfg_rdata` from the next cycle on.
  - All three bits reset to 0, and all other read bits are 0.
- R3: Bit 13 of the control word always reads 0. Writing 1 to it has no effect.
- R4: With hold-all = 1, a pending request is granted when any vector fetch, NOP, descriptor fetch or data phase completes.
- R5: With all three bits at 0, the only boundary inside a transfer that grants a pending request is the completion of the NOP phase.
- R6: With hold-all = 0, yield-select-A = 1 and yield-select-B = 0, a pending request is granted only when a data round completes, never at the NOP phase.
- R7: With hold-all = 0 and yield-select-B = 1, no grant is given inside a transfer, whatever yield-select-A holds. The request is served once the transfer, including write-back, is complete.
- R8: Requests are latched and grants are timed as follows:
  - A request pulse on `cpu_req`, even one cycle long, stays pending until it is served.
  - `cpu_gnt` rises in the cycle after the allowed boundary completes.
  - `cpu_gnt` stays high while `cpu_req` is high.
  - In the cycle after `cpu_req` is seen low during a grant, the sequencer is in the phase that follows the boundary.
- R9: A release happens only when a request is pending. Without one, the next phase follows the completed one with no gap cycle.
- R10: Starts and completion behave as follows:
  - `xfer_start` is accepted only in idle, with no request pending and a round count from 1 to 255. A count of 0 is ignored.
  - `xfer_done` is high for exactly one cycle, the cycle after write-back completes. That is rounds+5 cycles after the start cycle when nothing stalls.
- R11: In idle, a pending request is granted in the next cycle. When it is dropped, the sequencer returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data |
| xfer_start | input | 1 | Start request for a transfer |
| xfer_rounds | input | 8 | Number of data rounds for the started transfer |
| bus_phase_done | input | 1 | Completion strobe of the current phase from the modelled bus |
| bus_phase | output | 3 | Current phase code |
| cpu_req | input | 1 | CPU external bus request |
| cpu_gnt | output | 1 | Bus granted to the CPU |
| xfer_done | output | 1 | One-cycle pulse after write-back |

## Verification
Every result here is due one clock edge after the cycle that causes it:
- A new phase follows the cycle in which `bus_phase_done` was high.
- The grant follows the completing boundary.
- The resumed phase follows the cycle in which the request is seen low.
- `xfer_done` follows write-back.
- A register write shows on the read port in the next cycle.

The bench drives inputs just after the falling edge. It steps a reference model by the same single edge. It compares phase, grant, done and read data at the next falling edge, so each expected value is checked in exactly the cycle it is due. A directed count also checks the rounds+5 latency from start to done.

// File: rtl/byc_pkg.sv
package byc_pkg;

    localparam int HOLD_BIT = 15;
    localparam int SELA_BIT = 14;
    localparam int RSVD_BIT = 13;
    localparam int SELB_BIT = 12;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_VEC   = 3'd1,
        PH_NOP   = 3'd2,
        PH_DESC  = 3'd3,
        PH_DATA  = 3'd4,
        PH_WBACK = 3'd5,
        PH_GRANT = 3'd6
    } phase_e;

    typedef struct packed {
        logic hold_all;
        logic sel_a;
        logic sel_b;
    } policy_t;

    // Boundary permission at the end of a phase inside a transfer.
    function automatic logic may_yield(policy_t p, phase_e ph);
        logic ok;
        case (ph)
            PH_VEC:  ok = p.hold_all;
            PH_NOP:  ok = p.hold_all | (~p.sel_a & ~p.sel_b);
            PH_DESC: ok = p.hold_all;
            PH_DATA: ok = p.hold_all | (p.sel_a & ~p.sel_b);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/byc_ctrl_reg.sv
module byc_ctrl_reg
    import byc_pkg::*;
#(
    parameter int REG_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [REG_W-1:0] wdata_i,
    output logic [REG_W-1:0] rdata_o,
    output policy_t          policy_o
);

    typedef struct packed {
        policy_t pol;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.pol.hold_all = wdata_i[HOLD_BIT];
            st_d.pol.sel_a    = wdata_i[SELA_BIT];
            st_d.pol.sel_b    = wdata_i[SELB_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rdata_o           = '0;
        rdata_o[HOLD_BIT] = st_q.pol.hold_all;
        rdata_o[SELA_BIT] = st_q.pol.sel_a;
        rdata_o[SELB_BIT] = st_q.pol.sel_b;
    end

    assign policy_o = st_q.pol;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i;

    // R3: a write never makes the reserved bit visible
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o[RSVD_BIT] == 1'b0));
    // R2: written policy bits appear on the read port next cycle
    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (rdata_o[HOLD_BIT] == $past(wdata_i[HOLD_BIT])));

endmodule

// File: rtl/byc_req_latch.sv
module byc_req_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cpu_req_i,
    input  logic clear_i,
    output logic pending_o
);

    typedef struct packed {
        logic seen;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cpu_req_i)     st_d.seen = 1'b1;
        if (clear_i)       st_d.seen = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending_o = st_q.seen | cpu_req_i;

    // R8: a request that is not being cleared stays pending
    p_req_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req_i && !clear_i) |=> pending_o);

endmodule

// File: rtl/byc_phase_seq.sv
module byc_phase_seq
    import byc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  policy_t          policy_i,
    input  logic             pending_i,
    input  logic             cpu_req_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] rounds_i,
    input  logic             phase_done_i,
    output phase_e           phase_o,
    output logic             gnt_o,
    output logic             done_o,
    output logic             release_end_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        phase_e           resume;
        logic [CNT_W-1:0] left;
        logic             done;
    } seq_state_t;

    seq_state_t st_d, st_q;
    phase_e     nxt;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        nxt       = PH_IDLE;
        case (st_q.phase)
            PH_VEC:   nxt = PH_NOP;
            PH_NOP:   nxt = PH_DESC;
            PH_DESC:  nxt = PH_DATA;
            PH_DATA:  nxt = (st_q.left == ONE) ? PH_WBACK : PH_DATA;
            default:  nxt = PH_IDLE;
        endcase

        case (st_q.phase)
            PH_IDLE: begin
                if (pending_i) begin
                    st_d.phase  = PH_GRANT;
                    st_d.resume = PH_IDLE;
                end else if (start_i && (rounds_i != '0)) begin
                    st_d.phase = PH_VEC;
                    st_d.left  = rounds_i;
                end
            end
            PH_GRANT: begin
                if (!cpu_req_i) st_d.phase = st_q.resume;
            end
            default: begin
                if (phase_done_i) begin
                    if (st_q.phase == PH_DATA) st_d.left = st_q.left - ONE;
                    if (st_q.phase == PH_WBACK) st_d.done = 1'b1;
                    if (pending_i && may_yield(policy_i, st_q.phase)) begin
                        st_d.phase  = PH_GRANT;
                        st_d.resume = nxt;
                    end else begin
                        st_d.phase = nxt;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase  <= PH_IDLE;
            st_q.resume <= PH_IDLE;
            st_q.left   <= '0;
            st_q.done   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_o       = st_q.phase;
    assign gnt_o         = (st_q.phase == PH_GRANT);
    assign done_o        = st_q.done;
    assign release_end_o = (st_q.phase == PH_GRANT) && !cpu_req_i;

    // R1: a phase without its done strobe holds
    p_stall_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase inside {PH_VEC, PH_NOP, PH_DESC, PH_DATA, PH_WBACK}) && !phase_done_i)
        |=> (st_q.phase == $past(st_q.phase)));
    // R7: yield-select-B without hold-all never grants mid-transfer
    p_selb_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!policy_i.hold_all && policy_i.sel_b &&
         (st_q.phase inside {PH_VEC, PH_NOP, PH_DESC, PH_DATA, PH_WBACK}))
        |=> !gnt_o);
    // R8: the grant persists while the CPU keeps requesting
    p_gnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt_o && cpu_req_i) |=> gnt_o);
    // R9: a grant only starts from a pending request
    p_gnt_needs_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gnt_o) |-> $past(pending_i));
    // R10: done is a single-cycle pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/bus_yield_ctrl.sv
module bus_yield_ctrl
    import byc_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             xfer_start,
    input  logic [CNT_W-1:0] xfer_rounds,
    input  logic             bus_phase_done,
    output logic [2:0]       bus_phase,
    input  logic             cpu_req,
    output logic             cpu_gnt,
    output logic             xfer_done
);

    policy_t pol;
    logic    pending;
    logic    rel_end;
    phase_e  ph;

    byc_ctrl_reg #(.REG_W(REG_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .wdata_i  (cfg_wdata),
        .rdata_o  (cfg_rdata),
        .policy_o (pol)
    );

    byc_req_latch u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .cpu_req_i (cpu_req),
        .clear_i   (rel_end),
        .pending_o (pending)
    );

    byc_phase_seq #(.CNT_W(CNT_W)) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .policy_i      (pol),
        .pending_i     (pending),
        .cpu_req_i     (cpu_req),
        .start_i       (xfer_start),
        .rounds_i      (xfer_rounds),
        .phase_done_i  (bus_phase_done),
        .phase_o       (ph),
        .gnt_o         (cpu_gnt),
        .done_o        (xfer_done),
        .release_end_o (rel_end)
    );

    assign bus_phase = ph;

    // R11: an idle pending request is granted on the next edge
    p_idle_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_phase == 3'd0 && pending) |=> cpu_gnt);

endmodule

// File: tb/tb_bus_yield_ctrl.sv
`timescale 1ns/1ps
module tb_bus_yield_ctrl;

    localparam int P_IDLE = 0, P_VEC = 1, P_NOP = 2, P_DESC = 3,
                   P_DATA = 4, P_WB = 5, P_GNT = 6;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [15:0] cfg_wdata = 0;
    logic [15:0] cfg_rdata;
    logic        xfer_start = 0;
    logic [7:0]  xfer_rounds = 0;
    logic        bus_phase_done = 1;
    logic [2:0]  bus_phase;
    logic        cpu_req = 0;
    logic        cpu_gnt;
    logic        xfer_done;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    // reference model state
    int m_ph, m_res, m_left;
    bit m_pend, m_done, m_hold, m_sela, m_selb;
    bit obs_done;

    always #4 clk = ~clk;

    bus_yield_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .xfer_start(xfer_start), .xfer_rounds(xfer_rounds),
        .bus_phase_done(bus_phase_done), .bus_phase(bus_phase), .cpu_req(cpu_req),
        .cpu_gnt(cpu_gnt), .xfer_done(xfer_done)
    );

    function automatic bit permit(int ph);
        case (ph)
            P_VEC:  return m_hold;
            P_NOP:  return m_hold | (!m_sela && !m_selb);
            P_DESC: return m_hold;
            P_DATA: return m_hold | (m_sela && !m_selb);
            default: return 0;
        endcase
    endfunction

    function automatic string gnt_tag();
        if (m_hold) return "R4 R8 R11";
        if (m_selb) return "R7 R8 R11";
        if (m_sela) return "R6 R8 R11";
        return "R5 R8 R11";
    endfunction

    function automatic logic [15:0] exp_rdata();
        return {m_hold, m_sela, 1'b0, m_selb, 12'h000};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare();
        check(bus_phase == 3'(m_ph), "R1 R8 R9 R11 phase", bus_phase, m_ph);
        check(cpu_gnt == (m_ph == P_GNT), gnt_tag(), cpu_gnt, m_ph == P_GNT);
        check(xfer_done == m_done, "R10 done", xfer_done, m_done);
        check(cfg_rdata == exp_rdata(), "R2 R3 readback", cfg_rdata, exp_rdata());
        obs_done = xfer_done;
    endtask

    task automatic model_step(input bit we, input logic [15:0] wd, input bit st,
                              input int rnd, input bit req, input bit pd);
        bit pend = m_pend | req;
        int nxt;
        int ph = m_ph;
        m_done = 0;
        case (ph)
            P_VEC:  nxt = P_NOP;
            P_NOP:  nxt = P_DESC;
            P_DESC: nxt = P_DATA;
            P_DATA: nxt = (m_left == 1) ? P_WB : P_DATA;
            default: nxt = P_IDLE;
        endcase
        if (ph == P_IDLE) begin
            if (pend) begin m_ph = P_GNT; m_res = P_IDLE; end
            else if (st && rnd != 0) begin m_ph = P_VEC; m_left = rnd; end
        end else if (ph == P_GNT) begin
            if (!req) m_ph = m_res;
        end else if (pd) begin
            if (ph == P_DATA) m_left--;
            if (ph == P_WB) m_done = 1;
            if (pend && permit(ph)) begin m_ph = P_GNT; m_res = nxt; end
            else m_ph = nxt;
        end
        m_pend = pend && !(ph == P_GNT && !req);
        if (we) begin m_hold = wd[15]; m_sela = wd[14]; m_selb = wd[12]; end
    endtask

    task automatic cyc(input bit we, input logic [15:0] wd, input bit st,
                       input int rnd, input bit req, input bit pd);
        @(negedge clk);
        compare();
        cfg_we = we; cfg_wdata = wd; xfer_start = st; xfer_rounds = 8'(rnd);
        cpu_req = req; bus_phase_done = pd;
        model_step(we, wd, st, rnd, req, pd);
    endtask

    task automatic idle_cyc(input bit req);
        cyc(0, 16'h0, 0, 0, req, 1);
    endtask

    // Runs one transfer under a policy; request raised at phase index req_at, held hold cycles after grant.
    task automatic run_xfer(input logic [15:0] pol, input int rounds, input int req_at, input int hold);
        bit req = 0;
        int held = 0;
        cyc(1, pol, 0, 0, 0, 1);
        cyc(0, 16'h0, 1, rounds, 0, 1);
        for (int i = 0; i < 600; i++) begin
            if (i == req_at) req = 1;
            if (m_ph == P_GNT) begin
                held++;
                if (held > hold) req = 0;
            end
            idle_cyc(req);
            if (m_ph == P_IDLE && !req && !m_pend && i > req_at) break;
        end
        idle_cyc(0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        m_ph = P_IDLE; m_res = P_IDLE; m_left = 0;
        m_pend = 0; m_done = 0; m_hold = 0; m_sela = 0; m_selb = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        // reset state, R2
        @(negedge clk);
        check(cfg_rdata == 16'h0000, "R2 reset value", cfg_rdata, 0);
        check(bus_phase == 3'd0, "R1 reset phase", bus_phase, 0);
        // R2 R3: all ones written, reserved stays 0
        cyc(1, 16'hFFFF, 0, 0, 0, 1);
        idle_cyc(0);
        check(cfg_rdata == 16'hD000, "R3 reserved bit", cfg_rdata, 16'hD000);
        cyc(1, 16'h2000, 0, 0, 0, 1);
        idle_cyc(0);
        check(cfg_rdata == 16'h0000, "R3 write of bit 13 alone", cfg_rdata, 0);

        // policies with a request raised early and late
        for (int p = 0; p < 5; p++) begin
            logic [15:0] pol;
            case (p)
                0: pol = 16'h0000;
                1: pol = 16'h4000;
                2: pol = 16'h1000;
                3: pol = 16'h5000;
                default: pol = 16'h8000;
            endcase
            for (int at = 0; at < 7; at++) run_xfer(pol, 3, at, at % 3);
        end

        // R9 R10: long transfer, no request, exact latency
        begin
            int n = 0;
            cyc(1, 16'h0000, 0, 0, 0, 1);
            cyc(0, 16'h0, 1, 255, 0, 1);
            for (int i = 1; i < 400; i++) begin
                idle_cyc(0);
                if (obs_done) begin n = i; break; end
            end
            check(n == 260, "R9 R10 start-to-done latency", n, 260);
        end

        // R10: zero rounds ignored
        cyc(0, 16'h0, 1, 0, 0, 1);
        idle_cyc(0);
        check(bus_phase == 3'd0, "R10 zero rounds ignored", bus_phase, 0);

        // R8: one-cycle request pulse in a select-A transfer, served at data round
        cyc(1, 16'h4000, 0, 0, 0, 1);
        cyc(0, 16'h0, 1, 2, 0, 1);
        idle_cyc(1);
        for (int i = 0; i < 12; i++) idle_cyc(0);
        check(bus_phase == 3'd0, "R8 pulse served and transfer completed", bus_phase, 0);

        // R1: stalls
        cyc(0, 16'h0, 1, 2, 0, 1);
        for (int i = 0; i < 20; i++) cyc(0, 16'h0, 0, 0, 0, i % 3 != 0);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            bit we = ($urandom % 40) == 0;
            bit st = ($urandom % 4) == 0;
            int rnd = ($urandom % 8 == 0) ? 0 : 1 + ($urandom % 4);
            bit pd = ($urandom % 8) != 0;
            bit req;
            if (m_ph == P_GNT) req = ($urandom % 3) != 0;
            else if (cpu_req) req = ($urandom % 2) != 0;
            else req = ($urandom % 12) == 0;
            cyc(we, 16'($urandom), st, rnd, req, pd);
        end
        idle_cyc(0);
        @(negedge clk);
        compare();

        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule